// File: doc/BRIEF.md
# Lane Metaframe Receive Checker

This block sits behind the descrambler of one serial lane. Each cycle it may take one 64-bit lane word, already aligned to its word boundary, together with a flag that marks the word as control or data. It finds the repeating metaframe structure in that stream, locks to it and then checks every metaframe. A metaframe opens with a sync word, carries a scrambler-state word in its second slot and ends with a diagnostic word. The diagnostic word holds a CRC-32 over the whole metaframe and two remote status bits.

The block removes every framing word from the stream: skip, sync, scrambler-state and diagnostic words. It forwards everything else one cycle later, in order. Separate outputs report the state of the lane: frame lock, pulses for a missing sync word, a changed scrambler state and a bad CRC, the captured remote status bits, and a ready level for the lane. The metaframe length is a static configuration input. Every word counts toward that length, skip words included.

Top module: `lane_mf_rx`

## Requirements
- R1: The sync slot recurs every `cfg_mf_len` accepted words (in_valid high), skip words included, for any length from 5 to 8191. Slot 0 holds the sync word, slot 1 the scrambler-state word and slot `cfg_mf_len`-1 the diagnostic word.
- R2: Each accepted word is forwarded on `out_word`/`out_ctrl` with `out_valid` one clock later, in order, unless it is a framing word. A framing word is a control word (in_ctrl=1) that is the sync pattern, or whose bits [63:58] are 6'b000111 (skip), 6'b001010 (scrambler state) or 6'b011001 (diagnostic). Framing words are dropped, and dropping a skip word raises no flag.
- R3: A sync word is a control word equal to 64'h78F678F678F678F6. While no lock is held, a sync word starts alignment. `frame_lock` rises one clock after the 4th consecutive sync word found in its expected slot. A missing sync before the 4th restarts the search.
- R4: While locked, `frame_lock` falls one clock after the 3rd consecutive sync slot without a valid sync word. A valid sync in a sync slot clears that count.
- R5: `sync_err` pulses for one clock, one clock after a word in a sync slot that is not a sync word, while aligned (counting toward lock or locked).
- R6: The CRC-32 uses polynomial 0x1EDC6F41, seed all ones and an inverted result. It runs over slots 0 to `cfg_mf_len`-1, 64 bits per word, bit 63 first, with bits [31:0] of the last word taken as zero. It is compared with bits [31:0] of the last word. `crc_err` pulses one clock after the last word when the two differ or when that word is not a diagnostic word.
- R7: When a diagnostic word arrives in the last slot while aligned, its bit 33 is loaded into `lane_status` and its bit 32 into `link_status`. Both hold until the next such word.
- R8: The scrambler-state word in slot 1 carries its state in bits [57:0]. The prediction is the state received in the previous metaframe. `scram_mismatch` pulses one clock after a slot-1 state word that differs from the prediction. The first state word after alignment starts is not compared.
- R9: `rx_ready` is high only while `frame_lock` is high and the most recent CRC check since alignment passed, or no check has occurred yet.
- R10: After a synchronous active-high reset, `out_valid`, `frame_lock`, `sync_err`, `scram_mismatch`, `crc_err`, `lane_status`, `link_status` and `rx_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A lane word is present this cycle |
| in_ctrl | input | 1 | Lane word is a control word |
| in_word | input | 64 | Descrambled, aligned lane word |
| cfg_mf_len | input | 13 | Metaframe length in words (5 to 8191) |
| out_valid | output | 1 | Forwarded word present |
| out_ctrl | output | 1 | Control flag of forwarded word |
| out_word | output | 64 | Forwarded word |
| frame_lock | output | 1 | Metaframe lock held |
| sync_err | output | 1 | Pulse: sync slot without a sync word |
| scram_mismatch | output | 1 | Pulse: scrambler state differs from prediction |
| crc_err | output | 1 | Pulse: metaframe CRC failed |
| lane_status | output | 1 | Remote lane status from diagnostic bit 33 |
| link_status | output | 1 | Remote link status from diagnostic bit 32 |
| rx_ready | output | 1 | Locked and last CRC check good |

## Verification
Lock acquisition is driven with clean metaframes at the shortest length, at an 8-word length with skip words mixed into the payload, and at the longest length. This shows that the slot count includes skip words and works at both length limits. Clean metaframes are then mixed with ones that carry a corrupted CRC, have no diagnostic word, hold a new scrambler state or lose their sync word. Each of these faults must raise only its own flag. The sync-loss patterns place a good sync between bad ones, and insert a bad sync before lock is reached. These patterns separate a consecutive-miss count from a total count, and a restarted lock search from one that continues.

// File: rtl/lane_mf_pkg.sv
package lane_mf_pkg;

    localparam int WORD_W = 64;
    localparam int CRC_W  = 32;
    localparam int TAG_W  = 6;
    localparam int SCR_W  = 58;

    localparam logic [WORD_W-1:0] SYNC_PATTERN = 64'h78F6_78F6_78F6_78F6;
    localparam logic [TAG_W-1:0]  TAG_SCRAM    = 6'b001010;
    localparam logic [TAG_W-1:0]  TAG_SKIP     = 6'b000111;
    localparam logic [TAG_W-1:0]  TAG_DIAG     = 6'b011001;
    localparam logic [CRC_W-1:0]  CRC_POLY     = 32'h1EDC_6F41;

    typedef enum logic [2:0] {
        K_DATA, K_SYNC, K_SCRAM, K_SKIP, K_DIAG, K_CTRL
    } word_kind_e;

    typedef enum logic [1:0] {
        ST_HUNT, ST_VERIFY, ST_LOCKED
    } lock_state_e;

    typedef struct packed {
        logic              ctrl;
        logic [WORD_W-1:0] data;
    } lane_word_t;

    function automatic word_kind_e classify(input lane_word_t w);
        word_kind_e k;
        if (!w.ctrl)                                     k = K_DATA;
        else if (w.data == SYNC_PATTERN)                 k = K_SYNC;
        else if (w.data[WORD_W-1 -: TAG_W] == TAG_SCRAM) k = K_SCRAM;
        else if (w.data[WORD_W-1 -: TAG_W] == TAG_SKIP)  k = K_SKIP;
        else if (w.data[WORD_W-1 -: TAG_W] == TAG_DIAG)  k = K_DIAG;
        else                                             k = K_CTRL;
        return k;
    endfunction

    // Advance the CRC register over one word, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] seed,
                                                   input logic [WORD_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = seed;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (c[CRC_W-1] ^ d[i]) c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else                   c = {c[CRC_W-2:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/lane_mf_lock.sv
module lane_mf_lock
    import lane_mf_pkg::*;
#(
    parameter int LEN_W  = 13,
    parameter int GOOD_N = 4,
    parameter int BAD_N  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  word_kind_e       kind,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             aligned,
    output logic             locked,
    output logic             frame_start,
    output logic             frame_end,
    output logic             state_slot,
    output logic             sync_err
);
    localparam int GW = $clog2(GOOD_N + 1);
    localparam int BW = $clog2(BAD_N + 1);

    lock_state_e      state;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] last_pos;
    logic [LEN_W-1:0] pos_next;
    logic [GW-1:0]    good_cnt;
    logic [BW-1:0]    bad_cnt;
    logic             sync_slot;
    logic             is_sync;

    always_comb begin
        last_pos    = cfg_len - LEN_W'(1);
        pos_next    = (pos == last_pos) ? '0 : pos + LEN_W'(1);
        aligned     = (state != ST_HUNT);
        locked      = (state == ST_LOCKED);
        is_sync     = (kind == K_SYNC);
        sync_slot   = aligned && (pos == '0);
        frame_start = valid && (sync_slot || (!aligned && is_sync));
        frame_end   = valid && aligned && (pos == last_pos);
        state_slot  = aligned && (pos == LEN_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            pos      <= '0;
            good_cnt <= '0;
            bad_cnt  <= '0;
            sync_err <= 1'b0;
        end else begin
            sync_err <= 1'b0;
            if (valid) begin
                case (state)
                    ST_HUNT: begin
                        if (is_sync) begin
                            state    <= ST_VERIFY;
                            pos      <= LEN_W'(1);
                            good_cnt <= GW'(1);
                        end
                    end
                    ST_VERIFY: begin
                        pos <= pos_next;
                        if (sync_slot) begin
                            if (is_sync) begin
                                good_cnt <= good_cnt + GW'(1);
                                if (good_cnt == GW'(GOOD_N - 1)) begin
                                    state   <= ST_LOCKED;
                                    bad_cnt <= '0;
                                end
                            end else begin
                                state    <= ST_HUNT;
                                pos      <= '0;
                                sync_err <= 1'b1;
                            end
                        end
                    end
                    default: begin
                        pos <= pos_next;
                        if (sync_slot) begin
                            if (is_sync) begin
                                bad_cnt <= '0;
                            end else begin
                                sync_err <= 1'b1;
                                if (bad_cnt == BW'(BAD_N - 1)) begin
                                    state   <= ST_HUNT;
                                    pos     <= '0;
                                    bad_cnt <= '0;
                                end else begin
                                    bad_cnt <= bad_cnt + BW'(1);
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/lane_mf_crc.sv
module lane_mf_crc
    import lane_mf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              start,
    input  logic              finish,
    input  logic              clear,
    input  word_kind_e        kind,
    input  logic [WORD_W-1:0] data,
    output logic              crc_err,
    output logic              crc_bad,
    output logic              lane_st,
    output logic              link_st
);
    logic [CRC_W-1:0]  acc;
    logic [CRC_W-1:0]  base;
    logic [CRC_W-1:0]  nxt;
    logic [WORD_W-1:0] masked;
    logic              pass;

    always_comb begin
        masked = finish ? {data[WORD_W-1:CRC_W], {CRC_W{1'b0}}} : data;
        base   = start ? {CRC_W{1'b1}} : acc;
        nxt    = crc_step(base, masked);
        pass   = (kind == K_DIAG) && (~nxt == data[CRC_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= {CRC_W{1'b1}};
            crc_err <= 1'b0;
            crc_bad <= 1'b0;
            lane_st <= 1'b0;
            link_st <= 1'b0;
        end else begin
            crc_err <= 1'b0;
            if (clear) crc_bad <= 1'b0;
            if (valid) begin
                acc <= nxt;
                if (finish) begin
                    crc_err <= !pass;
                    crc_bad <= !pass;
                    if (kind == K_DIAG) begin
                        lane_st <= data[CRC_W+1];
                        link_st <= data[CRC_W];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lane_mf_rx.sv
module lane_mf_rx
    import lane_mf_pkg::*;
#(
    parameter int LEN_W  = 13,
    parameter int GOOD_N = 4,
    parameter int BAD_N  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_ctrl,
    input  logic [63:0]      in_word,
    input  logic [LEN_W-1:0] cfg_mf_len,
    output logic             out_valid,
    output logic             out_ctrl,
    output logic [63:0]      out_word,
    output logic             frame_lock,
    output logic             sync_err,
    output logic             scram_mismatch,
    output logic             crc_err,
    output logic             lane_status,
    output logic             link_status,
    output logic             rx_ready
);
    lane_word_t       cur;
    word_kind_e       kind;
    logic             aligned;
    logic             frame_start;
    logic             frame_end;
    logic             state_slot;
    logic             crc_bad;
    logic [SCR_W-1:0] prev_state;
    logic             have_prev;

    always_comb begin
        cur  = '{ctrl: in_ctrl, data: in_word};
        kind = classify(cur);
    end

    lane_mf_lock #(.LEN_W(LEN_W), .GOOD_N(GOOD_N), .BAD_N(BAD_N)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .valid      (in_valid),
        .kind       (kind),
        .cfg_len    (cfg_mf_len),
        .aligned    (aligned),
        .locked     (frame_lock),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .state_slot (state_slot),
        .sync_err   (sync_err)
    );

    lane_mf_crc u_crc (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .start  (frame_start),
        .finish (frame_end),
        .clear  (!aligned),
        .kind   (kind),
        .data   (cur.data),
        .crc_err(crc_err),
        .crc_bad(crc_bad),
        .lane_st(lane_status),
        .link_st(link_status)
    );

    // Scrambler state is predicted to hold from one metaframe to the next.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_state     <= '0;
            have_prev      <= 1'b0;
            scram_mismatch <= 1'b0;
        end else begin
            scram_mismatch <= 1'b0;
            if (!aligned) have_prev <= 1'b0;
            if (in_valid && state_slot && kind == K_SCRAM) begin
                scram_mismatch <= have_prev && (prev_state != cur.data[SCR_W-1:0]);
                prev_state     <= cur.data[SCR_W-1:0];
                have_prev      <= 1'b1;
            end
        end
    end

    // Forwarding path: framing words vanish, the rest pass one cycle later.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ctrl  <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid && (kind == K_DATA || kind == K_CTRL);
            if (in_valid) begin
                out_ctrl <= cur.ctrl;
                out_word <= cur.data;
            end
        end
    end

    assign rx_ready = frame_lock && !crc_bad;

endmodule

// File: rtl/lane_mf_rx_sva.sv
module lane_mf_rx_sva
    import lane_mf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ctrl,
    input logic [63:0] in_word,
    input logic        out_valid,
    input logic        frame_lock,
    input logic        sync_err,
    input logic        scram_mismatch,
    input logic        crc_err,
    input logic        lane_status,
    input logic        link_status,
    input logic        rx_ready
);
    logic [TAG_W-1:0] tag;
    assign tag = in_word[63:58];

    p_skip_dropped_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl && tag == TAG_SKIP) |=> !out_valid);

    p_lock_on_sync_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_lock) |-> $past(in_valid && in_ctrl && in_word == SYNC_PATTERN));

    p_unlock_with_err_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_lock) |-> sync_err);

    p_crc_single_r6: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> !crc_err);

    p_lane_from_diag_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(lane_status) |-> $past(in_valid && in_ctrl && tag == TAG_DIAG));

    p_link_from_diag_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(link_status) |-> $past(in_valid && in_ctrl && tag == TAG_DIAG));

    p_mismatch_source_r8: assert property (@(posedge clk) disable iff (rst)
        scram_mismatch |-> $past(in_valid && in_ctrl && tag == TAG_SCRAM));

    p_ready_needs_lock_r9: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> frame_lock);

endmodule

bind lane_mf_rx lane_mf_rx_sva u_sva (.*);

// File: tb/lane_mf_rx_tb_top.sv
module lane_mf_rx_tb_top;

    localparam logic [63:0] T_SYNC = 64'h78F6_78F6_78F6_78F6;
    localparam logic [5:0]  T_SCR  = 6'b001010;
    localparam logic [5:0]  T_SKIP = 6'b000111;
    localparam logic [5:0]  T_DIAG = 6'b011001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ctrl = 1'b0;
    logic [63:0] in_word = '0;
    logic [12:0] cfg_mf_len = 13'd8;
    logic        out_valid, out_ctrl;
    logic [63:0] out_word;
    logic        frame_lock, sync_err, scram_mismatch, crc_err;
    logic        lane_status, link_status, rx_ready;

    int n_checks = 0;
    int n_fail = 0;
    int cnt_crc = 0;
    int cnt_sync = 0;
    int cnt_mm = 0;
    int seq = 0;
    logic [64:0] expq[$];

    always #4 clk = ~clk;

    lane_mf_rx dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_word(in_word), .cfg_mf_len(cfg_mf_len), .out_valid(out_valid),
        .out_ctrl(out_ctrl), .out_word(out_word), .frame_lock(frame_lock),
        .sync_err(sync_err), .scram_mismatch(scram_mismatch), .crc_err(crc_err),
        .lane_status(lane_status), .link_status(link_status), .rx_ready(rx_ready)
    );

    function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [63:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 63; b >= 0; b--) begin
            logic fb;
            fb = r[31] ^ d[b];
            r = r << 1;
            if (fb) r = r ^ 32'h1EDC6F41;
        end
        return r;
    endfunction

    function automatic bit passes(input logic c, input logic [63:0] d);
        if (!c) return 1'b1;
        if (d == T_SYNC) return 1'b0;
        if (d[63:58] == T_SKIP || d[63:58] == T_SCR || d[63:58] == T_DIAG) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard pops for forwarded words, pulse counters for flags.
    always @(negedge clk) begin
        if (!rst) begin
            if (crc_err) cnt_crc++;
            if (sync_err) cnt_sync++;
            if (scram_mismatch) cnt_mm++;
            if (out_valid) begin
                if (expq.size() == 0) begin
                    chk("R2", "unexpected forwarded word", {out_ctrl, out_word[62:0]}, 64'h0);
                end else begin
                    logic [64:0] e;
                    e = expq.pop_front();
                    chk("R2", "forwarded word", out_word, e[63:0]);
                    chk("R2", "forwarded ctrl", {63'h0, out_ctrl}, {63'h0, e[64]});
                end
            end
        end
    end

    task automatic put(input logic c, input logic [63:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_ctrl  = c;
        in_word  = d;
        if (passes(c, d)) expq.push_back({c, d});
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic send_frame(input int len, input int nskip, input bit bad_sync,
                              input bit bad_crc, input bit no_diag, input bit lane,
                              input bit link, input logic [57:0] scr);
        logic [31:0] c;
        c = '1;
        for (int p = 0; p < len; p++) begin
            logic        ct;
            logic [63:0] w;
            if (p == 0) begin
                ct = 1'b1;
                w = bad_sync ? (T_SYNC ^ 64'h1) : T_SYNC;
            end else if (p == 1) begin
                ct = 1'b1;
                w = {T_SCR, scr};
            end else if (p == len - 1) begin
                if (no_diag) begin
                    ct = 1'b0;
                    w = {32'hD1A6_0000, seq};
                    seq++;
                end else begin
                    ct = 1'b1;
                    w = {T_DIAG, 24'h0, lane, link, 32'h0};
                end
            end else if (p < 2 + nskip) begin
                ct = 1'b1;
                w = {T_SKIP, 58'h0};
            end else begin
                ct = 1'b0;
                w = {32'hDA7A_0000, seq};
                seq++;
            end
            if (p == len - 1 && !no_diag) begin
                c = ~tb_crc(c, w);
                w[31:0] = bad_crc ? (c ^ 32'h1) : c;
            end else begin
                c = tb_crc(c, w);
            end
            put(ct, w);
        end
        settle();
    endtask

    task automatic run_all();
        int d0;
        // R10 reset state
        do_reset();
        chk("R10", "out_valid", {63'h0, out_valid}, 64'h0);
        chk("R10", "frame_lock", {63'h0, frame_lock}, 64'h0);
        chk("R10", "rx_ready", {63'h0, rx_ready}, 64'h0);
        chk("R10", "flags", {60'h0, sync_err, scram_mismatch, crc_err, lane_status | link_status}, 64'h0);

        // Acquisition at length 8 with skip words inside the payload
        cfg_mf_len = 13'd8;
        for (int f = 0; f < 3; f++) send_frame(8, 2, 0, 0, 0, 0, 0, 58'hA5A5);
        chk("R3", "no lock after three syncs", {63'h0, frame_lock}, 64'h0);
        send_frame(8, 2, 0, 0, 0, 1, 0, 58'hA5A5);
        chk("R3", "lock after fourth sync", {63'h0, frame_lock}, 64'h1);
        chk("R9", "ready after lock", {63'h0, rx_ready}, 64'h1);
        chk("R6", "no crc error on clean frames", 64'(cnt_crc), 64'h0);
        chk("R2", "skips raise no sync error", 64'(cnt_sync), 64'h0);
        chk("R8", "steady state no mismatch", 64'(cnt_mm), 64'h0);
        chk("R7", "lane status bit 33", {63'h0, lane_status}, 64'h1);
        chk("R7", "link status bit 32", {63'h0, link_status}, 64'h0);

        // Corrupted CRC
        d0 = cnt_crc;
        send_frame(8, 1, 0, 1, 0, 1, 0, 58'hA5A5);
        chk("R6", "bad crc pulses", 64'(cnt_crc - d0), 64'h1);
        chk("R9", "ready drops on bad crc", {63'h0, rx_ready}, 64'h0);
        chk("R3", "lock kept on bad crc", {63'h0, frame_lock}, 64'h1);
        send_frame(8, 0, 0, 0, 0, 1, 0, 58'hA5A5);
        chk("R9", "ready back after good crc", {63'h0, rx_ready}, 64'h1);

        // Last slot without a diagnostic word
        d0 = cnt_crc;
        send_frame(8, 1, 0, 0, 1, 0, 1, 58'hA5A5);
        chk("R6", "missing diagnostic counts as crc error", 64'(cnt_crc - d0), 64'h1);
        chk("R7", "status held without diagnostic", {62'h0, lane_status, link_status}, 64'h2);
        send_frame(8, 2, 0, 0, 0, 0, 1, 58'hA5A5);
        chk("R7", "status swap", {62'h0, lane_status, link_status}, 64'h1);
        chk("R9", "ready after good frame", {63'h0, rx_ready}, 64'h1);

        // Scrambler state change
        d0 = cnt_mm;
        send_frame(8, 0, 0, 0, 0, 0, 1, 58'h3_1234_5678);
        chk("R8", "state change flagged", 64'(cnt_mm - d0), 64'h1);
        send_frame(8, 0, 0, 0, 0, 0, 1, 58'h3_1234_5678);
        chk("R8", "repeated new state accepted", 64'(cnt_mm - d0), 64'h1);

        // Lock loss: miss, good, miss, miss, miss
        d0 = cnt_sync;
        send_frame(8, 1, 1, 0, 0, 0, 1, 58'h3_1234_5678);
        chk("R5", "missing sync pulses", 64'(cnt_sync - d0), 64'h1);
        send_frame(8, 1, 0, 0, 0, 0, 1, 58'h3_1234_5678);
        send_frame(8, 1, 1, 0, 0, 0, 1, 58'h3_1234_5678);
        send_frame(8, 1, 1, 0, 0, 0, 1, 58'h3_1234_5678);
        chk("R4", "lock held after two consecutive misses", {63'h0, frame_lock}, 64'h1);
        send_frame(8, 1, 1, 0, 0, 0, 1, 58'h3_1234_5678);
        chk("R4", "lock lost after third miss", {63'h0, frame_lock}, 64'h0);
        chk("R9", "ready low without lock", {63'h0, rx_ready}, 64'h0);
        chk("R5", "one pulse per missing sync", 64'(cnt_sync - d0), 64'h4);

        // Search restarts on a miss before lock
        do_reset();
        d0 = cnt_sync;
        send_frame(8, 0, 0, 0, 0, 0, 0, 58'h7);
        send_frame(8, 0, 0, 0, 0, 0, 0, 58'h7);
        send_frame(8, 0, 1, 0, 0, 0, 0, 58'h7);
        chk("R5", "miss while verifying pulses", 64'(cnt_sync - d0), 64'h1);
        for (int f = 0; f < 3; f++) send_frame(8, 0, 0, 0, 0, 0, 0, 58'h7);
        chk("R3", "count restarted after miss", {63'h0, frame_lock}, 64'h0);
        send_frame(8, 0, 0, 0, 0, 0, 0, 58'h7);
        chk("R3", "lock after four fresh syncs", {63'h0, frame_lock}, 64'h1);

        // Shortest metaframe
        do_reset();
        cfg_mf_len = 13'd5;
        d0 = cnt_crc;
        for (int f = 0; f < 4; f++) send_frame(5, 0, 0, 0, 0, 1, 1, 58'h11);
        chk("R1", "lock at length 5", {63'h0, frame_lock}, 64'h1);
        chk("R1", "crc clean at length 5", 64'(cnt_crc - d0), 64'h0);
        chk("R7", "both status bits", {62'h0, lane_status, link_status}, 64'h3);

        // Longest metaframe
        do_reset();
        cfg_mf_len = 13'd8191;
        d0 = cnt_crc;
        for (int f = 0; f < 4; f++) send_frame(8191, 3, 0, 0, 0, 0, 0, 58'h22);
        chk("R1", "lock at length 8191", {63'h0, frame_lock}, 64'h1);
        chk("R1", "crc clean at length 8191", 64'(cnt_crc - d0), 64'h0);
        chk("R9", "ready at length 8191", {63'h0, rx_ready}, 64'h1);

        repeat (3) @(negedge clk);
        #1;
        chk("R2", "all expected words forwarded", 64'(expq.size()), 64'h0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual expired expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule